// File: doc/BRIEF.md
# Two-Wire Slave with Pointer-Addressed Register Banks

This block is a standard-mode two-wire (I2C) slave that runs entirely in the system clock domain. It oversamples the SCL and SDA lines through a short synchronizer chain and detects bus events from the synchronized values. It never drives the data line high. It only asserts an output-enable that pulls SDA low for acknowledges and for zero bits of read data. Behind the bus logic sit two banks of 64 byte-wide registers.

A master first sends the write form of the device address. The byte that follows is a control pointer. The pointer's low six bits select a register, bit 6 selects the second bank, and bit 7 asks for the index to advance after every data byte. Any further bytes in that transfer are stored. To read, the master sets the pointer, ends the transfer, and then opens a new one with the read form of the address. Bytes are then streamed out from the pointer until the master refuses one. While the busy input is high the slave declines its own address.

Top module: `i2cs_top`

## Requirements
- R1: After reset the enable is low, every register in both banks holds 0x00, and the pointer is 0x00 (bank 0, index 0, no advance).
- R2: The slave acknowledges the address byte of 7-bit address 0x62 (0xC4 to write, 0xC5 to read; the LSB is the read flag) by pulling SDA low during the ninth clock. For any other address it gives no acknowledge and drives nothing until the next start.
- R3: The general-call address 0x00 receives no acknowledge.
- R4: If busy is high when the address byte completes, both the write and read forms are refused, and the bytes that follow in that transfer change no register.
- R5: The first byte after an acknowledged write address becomes the pointer: bits 5:0 are the index, bit 6 picks bank 1 when set, and bit 7 enables advance. The pointer byte and every later data byte are acknowledged, and each data byte is stored at the current pointer.
- R6: With the advance bit set, the index increases by one modulo 64 after each stored byte, and the bank does not change.
- R7: With the advance bit clear, the index stays put. Repeated writes overwrite one register and repeated reads return the same register.
- R8: After an acknowledged read address, the slave sends the byte at the pointer MSB first, starting on the first clock after the acknowledge. It loads a new byte each time the master acknowledges. Each load advances the index modulo 64 when the advance bit is set.
- R9: Bank 0 and bank 1 are independent storage. A write to one never alters the other.
- R10: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released until the next start or stop.
- R11: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop returns the slave to idle and discards a partly received byte. A start at any point, including a repeated start with no stop before it, begins a new address phase.
- R12: The enable changes only while SCL is low.
- R13: The pointer is kept across stops and starts, so a read that does not set the pointer continues from where the previous transfer left it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| busy_i | input | 1 | When high, the slave declines its own address |
| sda_oe | output | 1 | High pulls SDA low; low leaves the line to the pull-up |

## Verification
The assertions check on every cycle that the enable moves only while SCL is low, and that it stays low when the slave is idle or ignoring the bus. They also check that the slave never acknowledges its address while busy, that a stop always lands in idle, that the pointer steps or holds correctly on each stored byte, and that the enable is asserted during write phases only in the ninth clock. Whether the data actually lands in the right bank and index, whether it comes back in order with wrap-around, which addresses are recognised, and what happens on aborted or repeated-start transfers can only be shown by the bench's transaction sequences against its own register model.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W     = 8;
    localparam int IDX_W      = 6;
    localparam int NUM_SPACES = 2;

    localparam logic [3:0] CNT_ACK = 4'd8;
    localparam logic [3:0] CNT_PRE = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WR,
        ST_RD,
        ST_SKIP
    } phase_e;

    // bit 7: advance, bit 6: bank select, bits 5:0: index
    typedef struct packed {
        logic             inc;
        logic             alt;
        logic [IDX_W-1:0] idx;
    } ptr_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic ptr_t ptr_step(ptr_t p);
        ptr_t n;
        n = p;
        if (p.inc) n.idx = p.idx + IDX_W'(1);
        return n;
    endfunction

    function automatic logic addr_hit(logic [6:0] a, logic [6:0] own);
        return (a == own) && (a != 7'd0);
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    localparam int LINES = 2;

    logic [LINES-1:0] line_in;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev;

    assign line_in = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '1;
            else     pipe <= {pipe[STAGES-2:0], line_in[g]};
        end
        assign cur[g] = pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= cur;
    end

    always_comb begin
        ev.sda   = cur[0];
        ev.rise  = cur[1] & ~prev[1];
        ev.fall  = ~cur[1] & prev[1];
        ev.start = cur[1] & prev[1] & prev[0] & ~cur[0];
        ev.stop  = cur[1] & prev[1] & ~prev[0] & cur[0];
    end

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
    import i2cs_pkg::*;
#(
    parameter int SPACES = NUM_SPACES,
    parameter int AW     = IDX_W,
    parameter int DW     = BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [$clog2(SPACES)-1:0] wr_space,
    input  logic [AW-1:0]             wr_idx,
    input  logic [DW-1:0]             wdata,
    input  logic [$clog2(SPACES)-1:0] rd_space,
    input  logic [AW-1:0]             rd_idx,
    output logic [DW-1:0]             rdata
);

    localparam int DEPTH = 1 << AW;
    localparam int SEL_W = $clog2(SPACES);

    logic [DW-1:0] bank_out [SPACES];

    for (genvar s = 0; s < SPACES; s++) begin : g_bank
        logic [DW-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we && (wr_space == SEL_W'(s))) begin
                mem[wr_idx] <= wdata;
            end
        end
        assign bank_out[s] = mem[rd_idx];
    end

    assign rdata = bank_out[rd_space];

endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h62,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic busy_i,
    output logic sda_oe
);

    bus_ev_t           ev;
    phase_e            state;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic [BYTE_W-1:0] rdata;
    ptr_t              ptr;
    logic              rw;
    logic              oe;
    logic              we;
    logic              active;

    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cs_regs #(.SPACES(NUM_SPACES), .AW(IDX_W), .DW(BYTE_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (we),
        .wr_space (ptr.alt),
        .wr_idx   (ptr.idx),
        .wdata    (sh),
        .rd_space (ptr.alt),
        .rd_idx   (ptr.idx),
        .rdata    (rdata)
    );

    assign active = (state != ST_IDLE) && (state != ST_SKIP);
    assign we     = ev.fall && (cnt == 4'd7) && (state == ST_WR);
    assign sda_oe = oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= CNT_PRE;
            sh    <= '0;
            tx    <= '0;
            ptr   <= '0;
            rw    <= 1'b0;
            oe    <= 1'b0;
        end else if (ev.stop) begin
            state <= ST_IDLE;
            oe    <= 1'b0;
        end else if (ev.start) begin
            state <= ST_ADDR;
            cnt   <= CNT_PRE;
            oe    <= 1'b0;
        end else if (active) begin
            if (ev.rise) begin
                if (cnt < CNT_ACK) begin
                    sh <= {sh[BYTE_W-2:0], ev.sda};
                end else if (cnt == CNT_ACK && state == ST_RD && ev.sda) begin
                    state <= ST_SKIP;
                end
            end
            if (ev.fall) begin
                if (cnt == CNT_PRE) begin
                    cnt <= '0;
                end else if (cnt == 4'd7) begin
                    cnt <= CNT_ACK;
                    unique case (state)
                        ST_ADDR: begin
                            if (addr_hit(sh[BYTE_W-1:1], DEV_ADDR) && !busy_i) begin
                                oe <= 1'b1;
                                rw <= sh[0];
                            end else begin
                                oe    <= 1'b0;
                                state <= ST_SKIP;
                            end
                        end
                        ST_PTR: begin
                            ptr <= ptr_t'(sh);
                            oe  <= 1'b1;
                        end
                        ST_WR: begin
                            ptr <= ptr_step(ptr);
                            oe  <= 1'b1;
                        end
                        ST_RD: oe <= 1'b0;
                        default: oe <= 1'b0;
                    endcase
                end else if (cnt == CNT_ACK) begin
                    cnt <= '0;
                    if ((state == ST_ADDR && rw) || state == ST_RD) begin
                        state <= ST_RD;
                        tx    <= {rdata[BYTE_W-2:0], 1'b0};
                        oe    <= ~rdata[BYTE_W-1];
                        ptr   <= ptr_step(ptr);
                    end else begin
                        oe <= 1'b0;
                        if (state == ST_ADDR)     state <= ST_PTR;
                        else if (state == ST_PTR) state <= ST_WR;
                    end
                end else begin
                    cnt <= cnt + 4'd1;
                    if (state == ST_RD) begin
                        oe <= ~tx[BYTE_W-1];
                        tx <= {tx[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
    import i2cs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       stop_seen,
    input logic       busy,
    input logic       sda_oe,
    input phase_e     state,
    input logic [3:0] cnt,
    input ptr_t       ptr,
    input logic       we
);

    // R12
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_i));

    // R10
    idle_released_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe);

    // R4
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) && $past(state) == ST_ADDR && $past(cnt) == 4'd7) |-> !$past(busy));

    // R11
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> state == ST_IDLE);

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (we && ptr.inc) |=> (ptr.idx == IDX_W'($past(ptr.idx) + IDX_W'(1))) && (ptr.alt == $past(ptr.alt)));

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !ptr.inc) |=> $stable(ptr));

    // R5
    wr_ack_slot_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_PTR || state == ST_WR) && sda_oe) |-> cnt == CNT_ACK);

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt <= CNT_ACK) || (cnt == CNT_PRE));

endmodule

bind i2cs_top i2cs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .stop_seen (ev.stop),
    .busy      (busy_i),
    .sda_oe    (sda_oe),
    .state     (state),
    .cnt       (cnt),
    .ptr       (ptr),
    .we        (we)
);

// File: tb/test_i2cs_top.sv
module test_i2cs_top;

    localparam int Q = 6;
    localparam logic [7:0] WADDR = 8'hC4;
    localparam logic [7:0] RADDR = 8'hC5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int scl_high_moves = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;

    logic [7:0] model [2][64];

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    i2cs_top i_i2cs_top (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .busy_i (busy),
        .sda_oe (sda_oe)
    );

    // R12 monitor: enable must not move while the bus clock is high
    always @(negedge clk) begin
        if (!rst && sda_oe !== prev_oe && scl_m) scl_high_moves++;
        prev_oe <= sda_oe;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b0; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b1; hq();
    endtask

    task automatic m_bit(input logic b);
        sda_m = b; hq();
        scl_m = 1'b1; hq(); hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic m_sample(output logic b);
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        b = sda_line; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic m_wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit(v[i]);
        m_sample(b);
        ack = ~b;
    endtask

    task automatic m_rbyte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_sample(b);
            v[i] = b;
        end
        m_bit(~mack);
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed * 31 + k * 17 + 5) ^ 8'h5A);
    endfunction

    task automatic do_write(input logic [7:0] p, input int n, input int seed, input string req);
        logic ack;
        logic [5:0] idx;
        logic [7:0] v;
        m_start();
        m_wbyte(WADDR, ack); check("R2 write address ack", int'(ack), 1);
        m_wbyte(p, ack);     check("R5 pointer ack", int'(ack), 1);
        idx = p[5:0];
        for (int k = 0; k < n; k++) begin
            v = pat(seed, k);
            m_wbyte(v, ack);
            check(req, int'(ack), 1);
            model[p[6]][idx] = v;
            if (p[7]) idx = idx + 6'd1;
        end
        m_stop();
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic ack;
        m_start();
        m_wbyte(WADDR, ack); check("R2 address ack", int'(ack), 1);
        m_wbyte(p, ack);     check("R5 pointer ack", int'(ack), 1);
        m_stop();
    endtask

    task automatic do_read(input logic [7:0] p, input int n, input string req);
        logic ack;
        logic [5:0] idx;
        logic [7:0] v;
        set_ptr(p);
        m_start();
        m_wbyte(RADDR, ack); check("R2 read address ack", int'(ack), 1);
        idx = p[5:0];
        for (int k = 0; k < n; k++) begin
            m_rbyte(k < n - 1, v);
            check(req, int'(v), int'(model[p[6]][idx]));
            if (p[7]) idx = idx + 6'd1;
        end
        m_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic b;
        logic [7:0] v;

        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 64; i++) model[s][i] = 8'h00;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1: released enable, zero pointer and zero contents
        check("R1 enable after reset", int'(sda_oe), 0);
        m_start();
        m_wbyte(RADDR, ack); check("R1 read address ack", int'(ack), 1);
        m_rbyte(1'b0, v);    check("R1 register 0 after reset", int'(v), 0);
        m_stop();
        do_read(8'h7F, 1, "R1 bank 1 index 63 after reset");

        // R2 / R3: sweep every 7-bit address
        for (int a = 0; a < 128; a++) begin
            m_start();
            m_wbyte({7'(a), 1'b0}, ack);
            m_stop();
            check(a == 0 ? "R3 general call no ack" : "R2 address match", int'(ack), int'(a == 8'h62));
        end

        // R5 / R6: fill both banks with wrap-around
        do_write(8'h90, 64, 1, "R6 bank 0 incrementing write ack");
        do_write(8'hEA, 64, 2, "R6 bank 1 incrementing write ack");

        // R8 / R9: read both banks back in full
        do_read(8'h80, 64, "R8 bank 0 read back");
        do_read(8'hC0, 64, "R9 bank 1 read back");
        do_read(8'hBE, 4,  "R8 read wraps past index 63");

        // R9: writing bank 1 leaves bank 0 alone
        do_write(8'h45, 1, 7, "R9 bank 1 single write ack");
        do_read(8'h05, 1, "R9 bank 0 index 5 unchanged");
        do_read(8'h45, 1, "R9 bank 1 index 5 updated");

        // R7: no advance
        do_write(8'h0A, 3, 9, "R7 repeated write ack");
        do_read(8'h0A, 3, "R7 repeated read same register");
        do_read(8'h8A, 2, "R7 neighbour untouched");

        // R4: busy refuses both address forms
        busy = 1'b1;
        m_start();
        m_wbyte(WADDR, ack); check("R4 busy write address nack", int'(ack), 0);
        m_wbyte(8'h87, ack);
        m_wbyte(8'hEE, ack); check("R4 busy data ignored", int'(ack), 0);
        m_stop();
        m_start();
        m_wbyte(RADDR, ack); check("R4 busy read address nack", int'(ack), 0);
        m_stop();
        busy = 1'b0;
        do_read(8'h07, 1, "R4 register untouched while busy");

        // R11: stop in the middle of a data byte
        m_start();
        m_wbyte(WADDR, ack);
        m_wbyte(8'h09, ack);
        for (int i = 0; i < 4; i++) m_bit(1'b1);
        m_stop();
        check("R11 enable after stop", int'(sda_oe), 0);
        do_read(8'h09, 1, "R11 partial byte discarded");

        // R11: repeated start without stop
        m_start();
        m_wbyte(WADDR, ack);
        m_wbyte(8'h8C, ack);
        m_start();
        m_wbyte(RADDR, ack); check("R11 repeated start read ack", int'(ack), 1);
        m_rbyte(1'b1, v);    check("R11 repeated start byte 0", int'(v), int'(model[0][12]));
        m_rbyte(1'b0, v);    check("R11 repeated start byte 1", int'(v), int'(model[0][13]));
        m_stop();

        // R10: master refuses a byte
        set_ptr(8'h83);
        m_start();
        m_wbyte(RADDR, ack);
        m_rbyte(1'b0, v);  check("R10 byte before nack", int'(v), int'(model[0][3]));
        m_sample(b);       check("R10 line released bit 1", int'(b), 1);
        check("R10 enable low after nack", int'(sda_oe), 0);
        m_sample(b);       check("R10 line released bit 2", int'(b), 1);
        m_stop();

        // R13: pointer kept across transfers
        do_write(8'hA0, 2, 11, "R13 write ack");
        m_start();
        m_wbyte(RADDR, ack); check("R13 read address ack", int'(ack), 1);
        m_rbyte(1'b0, v);    check("R13 read continues at index 34", int'(v), int'(model[0][34]));
        m_stop();

        hq();
        check("R12 enable moves only with bus clock low", scl_high_moves, 0);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule